// File: doc/BRIEF.md
# Rotating Predicated Register File

This block holds the general and predicate registers of a core that runs software-pipelined loops without unrolling them. There are 128 general registers of 64 bits, each with a deferred-exception tag bit, and 64 one-bit predicates. Each bank has a low static region whose logical numbers are used as physical indices unchanged. It also has a high rotating region, where logical numbers are renamed through a base counter before they reach storage.

A one-cycle rotate strobe moves both rotating windows down by one position. A value written to rotating logical register r is therefore found at logical r+1 after the next rotation, and the top of the region wraps to its bottom. A clear input returns both bases to zero.

The general bank has two combinational read ports and one write port. The predicate bank has one combinational read port and one write port. Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the incoming value.

Top module: `rot_pred_regfile`

## Requirements
- R1: Each general register stores 64 data bits and one tag bit, written together and returned together on the read port's data and tag outputs.
- R2: Logical general register 0 always reads data 0 with tag 0, and writes to it are dropped.
- R3: General registers 1 to 31 are never renamed: a value written there is read back at the same number whatever rotations or clears happen.
- R4: A logical general register r of 32 or above addresses physical register 32 + ((r − 32 + gb) mod 96), where gb is the current general base.
- R5: Predicate 0 always reads 1, and writes to it are dropped.
- R6: Predicates 1 to 15 are never renamed, and a logical predicate p of 16 or above addresses physical 16 + ((p − 16 + pb) mod 48), where pb is the current predicate base.
- R7: A rotate strobe, sampled at a rising edge, decrements the general base modulo 96 and the predicate base modulo 48. A value written to rotating logical register r in the rotate cycle then reads at r+1, with 127 followed by 32 and predicate 63 followed by 16.
- R8: Reset and the clear input set both bases to 0. Clear takes priority over a rotate strobe in the same cycle.
- R9: A read of the logical register being written in the same cycle returns the write data (and tag) combinationally. The mapping used is the one from before any rotate taking effect at that edge.
- R10: The two general read ports are independent and may read any pair of registers, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the rotating bases |
| rot_i | input | 1 | Rotate strobe, one cycle per loop iteration |
| clr_i | input | 1 | Return both rotating bases to zero |
| gr_ra_i | input | 7 | Logical general register, read port A |
| gr_ra_data_o | output | 64 | Read port A data |
| gr_ra_nat_o | output | 1 | Read port A deferred-exception tag |
| gr_rb_i | input | 7 | Logical general register, read port B |
| gr_rb_data_o | output | 64 | Read port B data |
| gr_rb_nat_o | output | 1 | Read port B deferred-exception tag |
| gr_we_i | input | 1 | General write enable |
| gr_wa_i | input | 7 | Logical general register to write |
| gr_wdata_i | input | 64 | General write data |
| gr_wnat_i | input | 1 | General write tag |
| pr_ra_i | input | 6 | Logical predicate to read |
| pr_rdata_o | output | 1 | Predicate read value |
| pr_we_i | input | 1 | Predicate write enable |
| pr_wa_i | input | 6 | Logical predicate to write |
| pr_wdata_i | input | 1 | Predicate write value |

## Verification
The case that matters is a write and a rotate strobe arriving in the same cycle, usually together with a read of the register being written. The write must land under the old base, while the following cycle's reads use the new one. The bench produces this case directly, writing r40, r127 and p63 with the strobe set and reading r41, r32 and p16 in the next cycle. It also produces the case through random stimulus that sets the strobe in roughly a quarter of cycles, mixed with clears and with clear and rotate together. Each read is judged against a reference model that applies writes under the pre-edge base and then updates the base, with clear taking priority.

// File: rtl/rrf_pkg.sv
`timescale 1ns/1ps
package rrf_pkg;
  localparam int DEF_DATA_W    = 64;
  localparam int DEF_GR_TOTAL  = 128;
  localparam int DEF_GR_STATIC = 32;
  localparam int DEF_PR_TOTAL  = 64;
  localparam int DEF_PR_STATIC = 16;
endpackage

// File: rtl/rrf_rot_base.sv
`timescale 1ns/1ps
// Rotating base counter: counts down modulo SIZE on rotate, clear wins.
module rrf_rot_base #(
  parameter int SIZE = 96,
  localparam int BW = $clog2(SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rot_i,
  input  logic          clr_i,
  output logic [BW-1:0] base_o
);
  logic [BW-1:0] base_q;
  logic [BW-1:0] base_d;
  logic          base_en;

  always_comb begin
    base_d = base_q;
    if (clr_i) begin
      base_d = '0;
    end else if (rot_i) begin
      if (base_q == '0) base_d = BW'(SIZE - 1);
      else              base_d = base_q - BW'(1);
    end
  end

  assign base_en = clr_i | rot_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign base_o = base_q;
endmodule

// File: rtl/rrf_rename.sv
`timescale 1ns/1ps
// Logical to physical index: static entries pass, rotating ones add the base.
module rrf_rename #(
  parameter int TOTAL  = 128,
  parameter int STATIC = 32,
  localparam int AW  = $clog2(TOTAL),
  localparam int ROT = TOTAL - STATIC,
  localparam int BW  = $clog2(ROT)
) (
  input  logic [AW-1:0] log_i,
  input  logic [BW-1:0] base_i,
  output logic [AW-1:0] phys_o
);
  int off;

  always_comb begin
    off = int'(log_i) - STATIC + int'(base_i);
    if (off >= ROT) off = off - ROT;
    if (int'(log_i) < STATIC) phys_o = log_i;
    else                      phys_o = AW'(STATIC + off);
  end
endmodule

// File: rtl/rrf_bank.sv
`timescale 1ns/1ps
// Storage bank: entry 0 is a constant, write-through bypass on every read port.
module rrf_bank #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 65,
  parameter int NRD   = 2,
  parameter logic [WIDTH-1:0] FIXED_VAL = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we_i,
  input  logic [AW-1:0]             widx_i,
  input  logic [WIDTH-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0]    rd_idx_i,
  output logic [NRD-1:0][WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] wr_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wr_en[i] = we_i && (widx_i == AW'(i)) && (i != 0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) mem_q[i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_idx_i[p] == '0)                       rd_data_o[p] = FIXED_VAL;
      else if (we_i && (widx_i == rd_idx_i[p]))     rd_data_o[p] = wdata_i;
      else                                         rd_data_o[p] = mem_q[rd_idx_i[p]];
    end
  end
endmodule

// File: rtl/rot_pred_regfile.sv
`timescale 1ns/1ps
module rot_pred_regfile
  import rrf_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int GR_TOTAL  = DEF_GR_TOTAL,
  parameter int GR_STATIC = DEF_GR_STATIC,
  parameter int PR_TOTAL  = DEF_PR_TOTAL,
  parameter int PR_STATIC = DEF_PR_STATIC,
  localparam int GAW = $clog2(GR_TOTAL),
  localparam int PAW = $clog2(PR_TOTAL),
  localparam int GBW = $clog2(GR_TOTAL - GR_STATIC),
  localparam int PBW = $clog2(PR_TOTAL - PR_STATIC),
  localparam int GWW = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rot_i,
  input  logic              clr_i,
  input  logic [GAW-1:0]    gr_ra_i,
  output logic [DATA_W-1:0] gr_ra_data_o,
  output logic              gr_ra_nat_o,
  input  logic [GAW-1:0]    gr_rb_i,
  output logic [DATA_W-1:0] gr_rb_data_o,
  output logic              gr_rb_nat_o,
  input  logic              gr_we_i,
  input  logic [GAW-1:0]    gr_wa_i,
  input  logic [DATA_W-1:0] gr_wdata_i,
  input  logic              gr_wnat_i,
  input  logic [PAW-1:0]    pr_ra_i,
  output logic              pr_rdata_o,
  input  logic              pr_we_i,
  input  logic [PAW-1:0]    pr_wa_i,
  input  logic              pr_wdata_i
);
  logic [GBW-1:0] gr_base;
  logic [PBW-1:0] pr_base;

  rrf_rot_base #(.SIZE(GR_TOTAL - GR_STATIC)) u_gr_base (
    .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .clr_i(clr_i), .base_o(gr_base));
  rrf_rot_base #(.SIZE(PR_TOTAL - PR_STATIC)) u_pr_base (
    .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .clr_i(clr_i), .base_o(pr_base));

  // General: index 0,1 read ports, index 2 write port.
  logic [2:0][GAW-1:0] gr_log;
  logic [2:0][GAW-1:0] gr_phys;
  assign gr_log = {gr_wa_i, gr_rb_i, gr_ra_i};

  for (genvar g = 0; g < 3; g++) begin : g_gr_map
    rrf_rename #(.TOTAL(GR_TOTAL), .STATIC(GR_STATIC)) u_map (
      .log_i(gr_log[g]), .base_i(gr_base), .phys_o(gr_phys[g]));
  end

  // Predicate: index 0 read port, index 1 write port.
  logic [1:0][PAW-1:0] pr_log;
  logic [1:0][PAW-1:0] pr_phys;
  assign pr_log = {pr_wa_i, pr_ra_i};

  for (genvar g = 0; g < 2; g++) begin : g_pr_map
    rrf_rename #(.TOTAL(PR_TOTAL), .STATIC(PR_STATIC)) u_map (
      .log_i(pr_log[g]), .base_i(pr_base), .phys_o(pr_phys[g]));
  end

  logic [1:0][GWW-1:0] gr_word;
  logic [0:0][0:0]     pr_word;

  rrf_bank #(.DEPTH(GR_TOTAL), .WIDTH(GWW), .NRD(2), .FIXED_VAL('0)) u_gr_bank (
    .clk(clk), .we_i(gr_we_i), .widx_i(gr_phys[2]),
    .wdata_i({gr_wnat_i, gr_wdata_i}),
    .rd_idx_i(gr_phys[1:0]), .rd_data_o(gr_word));

  rrf_bank #(.DEPTH(PR_TOTAL), .WIDTH(1), .NRD(1), .FIXED_VAL(1'b1)) u_pr_bank (
    .clk(clk), .we_i(pr_we_i), .widx_i(pr_phys[1]), .wdata_i(pr_wdata_i),
    .rd_idx_i(pr_phys[0]), .rd_data_o(pr_word));

  assign gr_ra_data_o = gr_word[0][DATA_W-1:0];
  assign gr_ra_nat_o  = gr_word[0][DATA_W];
  assign gr_rb_data_o = gr_word[1][DATA_W-1:0];
  assign gr_rb_nat_o  = gr_word[1][DATA_W];
  assign pr_rdata_o   = pr_word[0][0];
endmodule

// File: rtl/rrf_checker.sv
`timescale 1ns/1ps
module rrf_checker #(
  parameter int DATA_W    = 64,
  parameter int GR_TOTAL  = 128,
  parameter int GR_STATIC = 32,
  parameter int PR_TOTAL  = 64,
  parameter int PR_STATIC = 16,
  localparam int GAW = $clog2(GR_TOTAL),
  localparam int PAW = $clog2(PR_TOTAL),
  localparam int GBW = $clog2(GR_TOTAL - GR_STATIC),
  localparam int PBW = $clog2(PR_TOTAL - PR_STATIC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rot_i,
  input logic              clr_i,
  input logic [GAW-1:0]    gr_ra_i,
  input logic [DATA_W-1:0] gr_ra_data_o,
  input logic              gr_ra_nat_o,
  input logic [GAW-1:0]    gr_rb_i,
  input logic [DATA_W-1:0] gr_rb_data_o,
  input logic              gr_we_i,
  input logic [GAW-1:0]    gr_wa_i,
  input logic [DATA_W-1:0] gr_wdata_i,
  input logic              gr_wnat_i,
  input logic [PAW-1:0]    pr_ra_i,
  input logic              pr_rdata_o,
  input logic              pr_we_i,
  input logic [PAW-1:0]    pr_wa_i,
  input logic              pr_wdata_i,
  input logic [GBW-1:0]    gr_base,
  input logic [PBW-1:0]    pr_base
);
  logic [GAW-1:0] gr_follow;
  logic [PAW-1:0] pr_follow;
  assign gr_follow = (gr_wa_i == GAW'(GR_TOTAL - 1)) ? GAW'(GR_STATIC) : gr_wa_i + GAW'(1);
  assign pr_follow = (pr_wa_i == PAW'(PR_TOTAL - 1)) ? PAW'(PR_STATIC) : pr_wa_i + PAW'(1);

  assert_r0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_ra_i == '0) |-> (gr_ra_data_o == '0 && !gr_ra_nat_o));

  assert_p0_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_ra_i == '0) |-> pr_rdata_o);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we_i && gr_wa_i != '0 && gr_ra_i == gr_wa_i)
      |-> (gr_ra_data_o == gr_wdata_i && gr_ra_nat_o == gr_wnat_i));

  assert_gr_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we_i && rot_i && !clr_i && gr_wa_i >= GAW'(GR_STATIC))
      |=> ((gr_rb_i == $past(gr_follow) && !gr_we_i) ? (gr_rb_data_o == $past(gr_wdata_i)) : 1'b1));

  assert_pr_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we_i && rot_i && !clr_i && pr_wa_i >= PAW'(PR_STATIC))
      |=> ((pr_ra_i == $past(pr_follow) && !pr_we_i) ? (pr_rdata_o == $past(pr_wdata_i)) : 1'b1));

  assert_static_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we_i && gr_wa_i != '0 && gr_wa_i < GAW'(GR_STATIC))
      |=> ((gr_rb_i == $past(gr_wa_i) && !gr_we_i) ? (gr_rb_data_o == $past(gr_wdata_i)) : 1'b1));

  assert_base_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gr_base) < GR_TOTAL - GR_STATIC) && (32'(pr_base) < PR_TOTAL - PR_STATIC));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (gr_base == '0 && pr_base == '0));
endmodule

bind rot_pred_regfile rrf_checker #(
  .DATA_W(DATA_W), .GR_TOTAL(GR_TOTAL), .GR_STATIC(GR_STATIC),
  .PR_TOTAL(PR_TOTAL), .PR_STATIC(PR_STATIC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .clr_i(clr_i),
  .gr_ra_i(gr_ra_i), .gr_ra_data_o(gr_ra_data_o), .gr_ra_nat_o(gr_ra_nat_o),
  .gr_rb_i(gr_rb_i), .gr_rb_data_o(gr_rb_data_o),
  .gr_we_i(gr_we_i), .gr_wa_i(gr_wa_i), .gr_wdata_i(gr_wdata_i), .gr_wnat_i(gr_wnat_i),
  .pr_ra_i(pr_ra_i), .pr_rdata_o(pr_rdata_o),
  .pr_we_i(pr_we_i), .pr_wa_i(pr_wa_i), .pr_wdata_i(pr_wdata_i),
  .gr_base(gr_base), .pr_base(pr_base));

// File: tb/rot_pred_regfile_tb_top.sv
`timescale 1ns/1ps
module rot_pred_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk, rst_n, rot_i, clr_i;
  logic [6:0] gr_ra_i, gr_rb_i, gr_wa_i;
  logic [63:0] gr_ra_data_o, gr_rb_data_o, gr_wdata_i;
  logic gr_ra_nat_o, gr_rb_nat_o, gr_we_i, gr_wnat_i;
  logic [5:0] pr_ra_i, pr_wa_i;
  logic pr_rdata_o, pr_we_i, pr_wdata_i;

  rot_pred_regfile dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model, indexed by physical number
  logic [63:0] gmod [128];
  logic        nmod [128];
  logic        pmod [64];
  int gbase, pbase;
  int checks, fails;
  bit done;
  string dir_tag;

  function automatic int map_gr(int r, int b);
    if (r < 32) return r;
    return 32 + ((r - 32 + b) % 96);
  endfunction

  function automatic int map_pr(int p, int b);
    if (p < 16) return p;
    return 16 + ((p - 16 + b) % 48);
  endfunction

  task automatic chk(string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic string gr_tag(int r, bit byp);
    if (dir_tag != "") return dir_tag;
    if (r == 0) return "R2";
    if (byp) return "R9";
    if (r < 32) return "R3";
    return "R4";
  endfunction

  // Inputs are set after a falling edge; check reads, then model the rising edge.
  task automatic step();
    logic [63:0] ed; logic en; logic ep;
    bit byp;
    #1;
    // port A
    byp = gr_we_i && gr_wa_i != 0 && gr_wa_i == gr_ra_i;
    if (gr_ra_i == 0) begin ed = '0; en = 1'b0; end
    else if (byp) begin ed = gr_wdata_i; en = gr_wnat_i; end
    else begin ed = gmod[map_gr(gr_ra_i, gbase)]; en = nmod[map_gr(gr_ra_i, gbase)]; end
    chk(gr_tag(gr_ra_i, byp), {1'b0, gr_ra_data_o}, {1'b0, ed});
    chk((dir_tag != "") ? dir_tag : "R1", {64'd0, gr_ra_nat_o}, {64'd0, en});
    // port B
    byp = gr_we_i && gr_wa_i != 0 && gr_wa_i == gr_rb_i;
    if (gr_rb_i == 0) begin ed = '0; en = 1'b0; end
    else if (byp) begin ed = gr_wdata_i; en = gr_wnat_i; end
    else begin ed = gmod[map_gr(gr_rb_i, gbase)]; en = nmod[map_gr(gr_rb_i, gbase)]; end
    chk((dir_tag != "") ? dir_tag : "R10", {gr_rb_nat_o, gr_rb_data_o}, {en, ed});
    // predicate
    byp = pr_we_i && pr_wa_i != 0 && pr_wa_i == pr_ra_i;
    if (pr_ra_i == 0) ep = 1'b1;
    else if (byp) ep = pr_wdata_i;
    else ep = pmod[map_pr(pr_ra_i, pbase)];
    chk((dir_tag != "") ? dir_tag : (pr_ra_i == 0) ? "R5" : byp ? "R9" : "R6",
        {64'd0, pr_rdata_o}, {64'd0, ep});
    @(posedge clk);
    if (rst_n) begin
      if (gr_we_i && gr_wa_i != 0) begin
        gmod[map_gr(gr_wa_i, gbase)] = gr_wdata_i;
        nmod[map_gr(gr_wa_i, gbase)] = gr_wnat_i;
      end
      if (pr_we_i && pr_wa_i != 0) pmod[map_pr(pr_wa_i, pbase)] = pr_wdata_i;
      if (clr_i) begin gbase = 0; pbase = 0; end
      else if (rot_i) begin
        gbase = (gbase == 0) ? 95 : gbase - 1;
        pbase = (pbase == 0) ? 47 : pbase - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    rot_i = 0; clr_i = 0; gr_we_i = 0; pr_we_i = 0;
    gr_ra_i = 0; gr_rb_i = 0; pr_ra_i = 0;
    gr_wa_i = 0; gr_wdata_i = 0; gr_wnat_i = 0; pr_wa_i = 0; pr_wdata_i = 0;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; fails = 0; done = 0; dir_tag = "";
    gbase = 0; pbase = 0;
    for (int i = 0; i < 128; i++) begin gmod[i] = '0; nmod[i] = 0; end
    for (int i = 0; i < 64; i++) pmod[i] = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: r0 and p0 constants (R2, R5)
    dir_tag = "";
    step();
    // fill all logical registers under base zero (R8 reset base)
    for (int r = 1; r < 128; r++) begin
      idle(); gr_we_i = 1; gr_wa_i = 7'(r);
      gr_wdata_i = {$urandom, $urandom}; gr_wnat_i = 1'($urandom);
      if (r < 64) begin pr_we_i = 1; pr_wa_i = 6'(r); pr_wdata_i = 1'($urandom); end
      gr_ra_i = 7'(r); gr_rb_i = 7'(r - 1);
      step();
    end
    // R2 / R5: writes to index 0 dropped
    idle(); gr_we_i = 1; gr_wa_i = 0; gr_wdata_i = 64'hdead_beef_0000_0001; gr_wnat_i = 1;
    pr_we_i = 1; pr_wa_i = 0; pr_wdata_i = 0; step();
    idle(); dir_tag = "R2"; gr_ra_i = 0; gr_rb_i = 0; step();
    idle(); dir_tag = "R5"; pr_ra_i = 0; step();
    // R1: tag stored with data
    idle(); dir_tag = ""; gr_we_i = 1; gr_wa_i = 5; gr_wdata_i = 64'h0123_4567_89ab_cdef; gr_wnat_i = 1; step();
    idle(); dir_tag = "R1"; gr_ra_i = 5; gr_rb_i = 5; step();
    // R7: write with rotate, read at the next logical number
    idle(); dir_tag = ""; rot_i = 1; gr_we_i = 1; gr_wa_i = 40; gr_wdata_i = 64'h4040_4040_0000_0040;
    pr_we_i = 1; pr_wa_i = 63; pr_wdata_i = ~pmod[map_pr(16, (pbase + 47) % 48)]; step();
    idle(); dir_tag = "R7"; gr_rb_i = 41; gr_ra_i = 40; pr_ra_i = 16; step();
    idle(); dir_tag = ""; rot_i = 1; gr_we_i = 1; gr_wa_i = 127; gr_wdata_i = 64'h7f7f_0000_1111_2222; step();
    idle(); dir_tag = "R7"; gr_rb_i = 32; gr_ra_i = 127; step();
    // R9: bypass with rotate in the same cycle
    idle(); dir_tag = "R9"; rot_i = 1; gr_we_i = 1; gr_wa_i = 90; gr_wdata_i = 64'h9090_9090_9090_9090;
    gr_wnat_i = 1; gr_ra_i = 90; gr_rb_i = 90; step();
    // R3: static registers across many rotations; wraparound of both bases (R4)
    for (int k = 0; k < 100; k++) begin
      idle(); dir_tag = (k % 2 == 0) ? "R3" : ""; rot_i = 1;
      gr_ra_i = 7'(1 + (k % 31)); gr_rb_i = 7'($urandom_range(32, 127)); pr_ra_i = 6'($urandom_range(1, 63));
      step();
    end
    // R8: clear with rotate, then clear alone
    idle(); dir_tag = ""; clr_i = 1; rot_i = 1; step();
    idle(); dir_tag = "R8"; gr_ra_i = 50; gr_rb_i = 127; pr_ra_i = 40; step();
    idle(); dir_tag = ""; rot_i = 1; step(); step();
    idle(); clr_i = 1; step();
    idle(); dir_tag = "R8"; gr_ra_i = 33; gr_rb_i = 100; pr_ra_i = 17; step();
    // constrained random
    dir_tag = "";
    for (int k = 0; k < 4000; k++) begin
      idle();
      rot_i = ($urandom_range(0, 3) == 0);
      clr_i = ($urandom_range(0, 63) == 0);
      gr_we_i = 1'($urandom); gr_wa_i = 7'($urandom); gr_wdata_i = {$urandom, $urandom}; gr_wnat_i = 1'($urandom);
      pr_we_i = 1'($urandom); pr_wa_i = 6'($urandom); pr_wdata_i = 1'($urandom);
      gr_ra_i = ($urandom_range(0, 7) == 0) ? gr_wa_i : 7'($urandom);
      gr_rb_i = ($urandom_range(0, 7) == 0) ? gr_ra_i : 7'($urandom);
      pr_ra_i = ($urandom_range(0, 7) == 0) ? pr_wa_i : 6'($urandom);
      step();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule